// File: doc/BRIEF.md
# Interleaving DRAM Bank Decoder

This block turns a CPU byte address into a one-hot DRAM row-strobe select, a bank-relative row address and a column address. It serves four memory blocks. Each block holds one or two banks, and each block is set up through static configuration inputs: a start address, a two-bit depth code, a two-bank flag and an interleave enable. A global input chooses 2 KB or 4 KB pages.

Interleaving is done by folding the page-select address bit into the block decode. That bit is address bit 11 for 2 KB pages and bit 12 for 4 KB pages. An interleaved bank answers on every other page, and the address range it decodes is twice its own size. The page-select bit is removed from the bank-relative offset before the row and column are formed. The block also reports whether the access falls in the row already open on the selected strobe line, so that a downstream timing engine can use page-mode cycles.

Addresses enter on a valid/ready channel, and results leave on a second valid/ready channel through a single register stage. Back-pressure rules:
- An address is accepted on a rising edge where `in_valid` and `in_ready` are both high.
- `in_ready` is high whenever the output register is empty or is being drained in that same cycle.
- While `out_valid` is high and `out_ready` is low, every result output holds its value and no new address is taken.

Top module: `dram_ilv_decoder`

## Requirements
- R1: A single-bank block with interleave off matches addresses from its start up to start + 2^(20+2·size) − 1. A match drives strobe line n for block n.
- R2: The page-select bit is address bit 11 when `cfg_page4k`=0 and bit 12 when `cfg_page4k`=1. The column is formed from offset bits [pagebit−1:2].
- R3: A single-bank block with interleave on decodes a range twice its bank size. An even-numbered block matches only when the page-select bit is 0, and an odd-numbered block matches only when it is 1.
- R4: A two-bank block always interleaves, and its interleave enable has no effect. Page-select bit 0 selects strobe line n and bit 1 selects strobe line n+4, over a doubled range starting at the single start address.
- R5: An even block and an odd block that share a start address and both have interleave on split consecutive pages between them.
- R6: When more than one block matches, the lowest-numbered block is selected and `out_conflict`=1. Otherwise `out_conflict`=0.
- R7: When no block matches, `out_miss`=1, `out_ras`=0 and `out_hit`=0.
- R8: `out_hit`=1 only when the selected strobe line's last accepted access used the same row. Reset clears all open rows. Misses do not change them, and an access on one line leaves the other lines' rows unchanged.
- R9: Row and column come from the offset within the block range with the page-select bit removed when interleaved: column = bits [pagebit−1:2], row = bits above pagebit.
- R10: A result appears on the outputs the cycle after acceptance. It holds stable while `out_valid`=1 and `out_ready`=0.
- R11: At most one bit of `out_ras` is ever high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_start | input | 112 | Start address for each block, 28 bits per block, block n at [28n+27:28n] |
| cfg_size | input | 8 | Depth code for each block, 2 bits per block; a bank is 2^(20+2·code) bytes |
| cfg_dual | input | 4 | Two-bank flag for each block |
| cfg_ilv | input | 4 | Interleave enable for each block |
| cfg_page4k | input | 1 | 1: 4 KB pages (bit 12); 0: 2 KB pages (bit 11) |
| in_valid | input | 1 | Address valid |
| in_ready | output | 1 | Decoder can take an address |
| in_addr | input | 28 | CPU byte address |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_ras | output | 8 | One-hot strobe select; line n+4 is the second bank of block n |
| out_row | output | 17 | Bank-relative row address |
| out_col | output | 10 | Column address (word units) |
| out_hit | output | 1 | Access falls in the open row of the selected line |
| out_miss | output | 1 | No block matched |
| out_conflict | output | 1 | More than one block matched |

## Verification
Every result, including the page-hit flag, is due exactly one clock after the edge that accepts the address. The bench drives an address on a falling edge and samples all outputs on the next falling edge, which is half a period after the register has loaded. For the stall case, the bench holds `out_ready` low for several cycles and checks at each falling edge that the earlier result is still present and `in_ready` is low. It then releases `out_ready` and expects the waiting address's result one falling edge later and an empty output one edge after that.

// File: rtl/dram_dec_pkg.sv
package dram_dec_pkg;
  localparam int PAGE_LG_SMALL = 11;
  localparam int BYTE_LG       = 2;
  localparam int SIZE_W        = 2;
endpackage

// File: rtl/dram_blk_decode.sv
module dram_blk_decode #(
  parameter int ADDR_W      = 28,
  parameter int BANK_MIN_LG = 20,
  parameter int BLK_IDX     = 0,
  parameter int ROW_W       = 17,
  parameter int COL_W       = 10
) (
  input  logic [ADDR_W-1:0]               addr,
  input  logic [ADDR_W-1:0]               start,
  input  logic [dram_dec_pkg::SIZE_W-1:0] size,
  input  logic                            dual,
  input  logic                            ilv,
  input  logic                            page4k,
  output logic                            match,
  output logic                            upper_bank,
  output logic [ROW_W-1:0]                row,
  output logic [COL_W-1:0]                col
);
  localparam int  PG_SMALL = dram_dec_pkg::PAGE_LG_SMALL;
  localparam bit  ODD_BLK  = (BLK_IDX % 2) == 1;

  int                ilb;
  int                dec_lg;
  logic              ilv_on;
  logic              ibit;
  logic              base_ok;
  logic              pol_ok;
  logic [ADDR_W-1:0] span_mask;
  logic [ADDR_W-1:0] low_mask;
  logic [ADDR_W-1:0] off;
  logic [ADDR_W-1:0] comp;

  always_comb begin
    ilb       = page4k ? PG_SMALL + 1 : PG_SMALL;
    ilv_on    = dual | ilv;
    dec_lg    = BANK_MIN_LG + 2 * int'(size) + (ilv_on ? 1 : 0);
    span_mask = (ADDR_W'(1) << dec_lg) - ADDR_W'(1);
    low_mask  = (ADDR_W'(1) << ilb) - ADDR_W'(1);
    ibit      = addr[ilb];
    // upper bits above the decoded span must equal the start address
    base_ok   = ((addr ^ start) & ~span_mask) == '0;
    // single-bank interleave: parity of block number picks page polarity
    pol_ok    = dual | ~ilv | (ibit == ODD_BLK);
    match     = base_ok & pol_ok;
    upper_bank = dual & ibit;
    off       = addr & span_mask;
    // squeeze the page-select bit out of the offset when interleaving
    comp      = ilv_on ? (((off >> (ilb + 1)) << ilb) | (off & low_mask)) : off;
    row       = ROW_W'(comp >> ilb);
    col       = COL_W'((comp & low_mask) >> dram_dec_pkg::BYTE_LG);
  end
endmodule

// File: rtl/dram_bank_select.sv
module dram_bank_select #(
  parameter int NBLK  = 4,
  parameter int ROW_W = 17,
  parameter int COL_W = 10
) (
  input  logic [NBLK-1:0]       match,
  input  logic [NBLK-1:0]       upper,
  input  logic [NBLK*ROW_W-1:0] rows,
  input  logic [NBLK*COL_W-1:0] cols,
  output logic [2*NBLK-1:0]     ras,
  output logic [ROW_W-1:0]      row,
  output logic [COL_W-1:0]      col,
  output logic                  miss,
  output logic                  conflict
);
  localparam int CNT_W = $clog2(NBLK + 1);

  logic [CNT_W-1:0] n_match;

  always_comb begin
    ras     = '0;
    row     = '0;
    col     = '0;
    n_match = '0;
    // walk downward so the lowest-numbered matching block is the last writer
    for (int i = NBLK - 1; i >= 0; i--) begin
      if (match[i]) begin
        n_match = n_match + CNT_W'(1);
        ras     = '0;
        if (upper[i]) ras[i + NBLK] = 1'b1;
        else          ras[i]        = 1'b1;
        row = rows[i*ROW_W +: ROW_W];
        col = cols[i*COL_W +: COL_W];
      end
    end
    miss     = (n_match == '0);
    conflict = (n_match > CNT_W'(1));
  end
endmodule

// File: rtl/dram_open_page.sv
module dram_open_page #(
  parameter int NLINE = 8,
  parameter int ROW_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic [NLINE-1:0] ras,
  input  logic [ROW_W-1:0] row,
  output logic             hit
);
  logic [NLINE-1:0] open_v;
  logic [NLINE-1:0] line_hit;

  generate
    for (genvar g = 0; g < NLINE; g++) begin : g_line
      logic [ROW_W-1:0] open_row;

      always_ff @(posedge clk) begin
        if (!rst_n)                open_v[g] <= 1'b0;
        else if (upd && ras[g])    open_v[g] <= 1'b1;
      end

      always_ff @(posedge clk) begin
        if (upd && ras[g]) open_row <= row;
      end

      assign line_hit[g] = ras[g] & open_v[g] & (open_row == row);
    end
  endgenerate

  assign hit = |line_hit;
endmodule

// File: rtl/dram_ilv_decoder.sv
module dram_ilv_decoder #(
  parameter int NBLK        = 4,
  parameter int ADDR_W      = 28,
  parameter int BANK_MIN_LG = 20
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [NBLK*ADDR_W-1:0]               cfg_start,
  input  logic [NBLK*dram_dec_pkg::SIZE_W-1:0] cfg_size,
  input  logic [NBLK-1:0]                      cfg_dual,
  input  logic [NBLK-1:0]                      cfg_ilv,
  input  logic                                 cfg_page4k,
  input  logic                                 in_valid,
  output logic                                 in_ready,
  input  logic [ADDR_W-1:0]                    in_addr,
  output logic                                 out_valid,
  input  logic                                 out_ready,
  output logic [2*NBLK-1:0]                    out_ras,
  output logic [ADDR_W-dram_dec_pkg::PAGE_LG_SMALL-1:0] out_row,
  output logic [dram_dec_pkg::PAGE_LG_SMALL+1-dram_dec_pkg::BYTE_LG-1:0] out_col,
  output logic                                 out_hit,
  output logic                                 out_miss,
  output logic                                 out_conflict
);
  localparam int SW    = dram_dec_pkg::SIZE_W;
  localparam int ROW_W = ADDR_W - dram_dec_pkg::PAGE_LG_SMALL;
  localparam int COL_W = dram_dec_pkg::PAGE_LG_SMALL + 1 - dram_dec_pkg::BYTE_LG;
  localparam int NLINE = 2 * NBLK;

  logic [NBLK-1:0]       blk_match;
  logic [NBLK-1:0]       blk_upper;
  logic [NBLK*ROW_W-1:0] blk_rows;
  logic [NBLK*COL_W-1:0] blk_cols;

  generate
    for (genvar b = 0; b < NBLK; b++) begin : g_blk
      dram_blk_decode #(
        .ADDR_W     (ADDR_W),
        .BANK_MIN_LG(BANK_MIN_LG),
        .BLK_IDX    (b),
        .ROW_W      (ROW_W),
        .COL_W      (COL_W)
      ) u_dec (
        .addr      (in_addr),
        .start     (cfg_start[b*ADDR_W +: ADDR_W]),
        .size      (cfg_size[b*SW +: SW]),
        .dual      (cfg_dual[b]),
        .ilv       (cfg_ilv[b]),
        .page4k    (cfg_page4k),
        .match     (blk_match[b]),
        .upper_bank(blk_upper[b]),
        .row       (blk_rows[b*ROW_W +: ROW_W]),
        .col       (blk_cols[b*COL_W +: COL_W])
      );
    end
  endgenerate

  logic [NLINE-1:0] sel_ras;
  logic [ROW_W-1:0] sel_row;
  logic [COL_W-1:0] sel_col;
  logic             sel_miss;
  logic             sel_conflict;
  logic             sel_hit;

  dram_bank_select #(.NBLK(NBLK), .ROW_W(ROW_W), .COL_W(COL_W)) u_sel (
    .match   (blk_match),
    .upper   (blk_upper),
    .rows    (blk_rows),
    .cols    (blk_cols),
    .ras     (sel_ras),
    .row     (sel_row),
    .col     (sel_col),
    .miss    (sel_miss),
    .conflict(sel_conflict)
  );

  logic accept;
  assign in_ready = ~out_valid | out_ready;
  assign accept   = in_valid & in_ready;

  dram_open_page #(.NLINE(NLINE), .ROW_W(ROW_W)) u_page (
    .clk  (clk),
    .rst_n(rst_n),
    .upd  (accept & ~sel_miss),
    .ras  (sel_ras),
    .row  (sel_row),
    .hit  (sel_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_ras      <= '0;
      out_row      <= '0;
      out_col      <= '0;
      out_hit      <= 1'b0;
      out_miss     <= 1'b0;
      out_conflict <= 1'b0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (accept) begin
        out_ras      <= sel_ras;
        out_row      <= sel_row;
        out_col      <= sel_col;
        out_hit      <= sel_hit;
        out_miss     <= sel_miss;
        out_conflict <= sel_conflict;
      end
    end
  end
endmodule

// File: rtl/dram_ilv_decoder_chk.sv
module dram_ilv_decoder_chk #(
  parameter int NLINE = 8,
  parameter int ROW_W = 17,
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [NLINE-1:0] out_ras,
  input logic [ROW_W-1:0] out_row,
  input logic [COL_W-1:0] out_col,
  input logic             out_hit,
  input logic             out_miss,
  input logic             out_conflict
);
  // R11
  ras_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0(out_ras));

  // R7
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_miss) |-> (out_ras == '0 && !out_hit));

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_ras) && $stable(out_row)
                                   && $stable(out_col) && $stable(out_hit)));

  // R10
  accept_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R6
  conflict_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_conflict) |-> (!out_miss && out_ras != '0));

  // R8
  hit_needs_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_hit) |-> (!out_miss && $countones(out_ras) == 1));
endmodule

bind dram_ilv_decoder dram_ilv_decoder_chk #(
  .NLINE(2 * NBLK),
  .ROW_W(ADDR_W - dram_dec_pkg::PAGE_LG_SMALL),
  .COL_W(dram_dec_pkg::PAGE_LG_SMALL + 1 - dram_dec_pkg::BYTE_LG)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_ras     (out_ras),
  .out_row     (out_row),
  .out_col     (out_col),
  .out_hit     (out_hit),
  .out_miss    (out_miss),
  .out_conflict(out_conflict)
);

// File: tb/dram_ilv_decoder_test.sv
`timescale 1ns/1ps
module dram_ilv_decoder_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic [111:0] cfg_start;
  logic [7:0]   cfg_size;
  logic [3:0]   cfg_dual;
  logic [3:0]   cfg_ilv;
  logic         cfg_page4k;
  logic         in_valid;
  logic         in_ready;
  logic [27:0]  in_addr;
  logic         out_valid;
  logic         out_ready;
  logic [7:0]   out_ras;
  logic [16:0]  out_row;
  logic [9:0]   out_col;
  logic         out_hit;
  logic         out_miss;
  logic         out_conflict;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  dram_ilv_decoder uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_start(cfg_start), .cfg_size(cfg_size), .cfg_dual(cfg_dual),
    .cfg_ilv(cfg_ilv), .cfg_page4k(cfg_page4k),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_ras(out_ras), .out_row(out_row), .out_col(out_col),
    .out_hit(out_hit), .out_miss(out_miss), .out_conflict(out_conflict)
  );

  task automatic set_blk(input int b, input logic [27:0] st, input logic [1:0] sz,
                         input logic d, input logic il);
    cfg_start[b*28 +: 28] = st;
    cfg_size[b*2 +: 2]    = sz;
    cfg_dual[b]           = d;
    cfg_ilv[b]            = il;
  endtask

  // four plain single-bank 1 MB blocks, far apart
  task automatic cfg_plain();
    set_blk(0, 28'h0000000, 2'd0, 1'b0, 1'b0);
    set_blk(1, 28'h1000000, 2'd0, 1'b0, 1'b0);
    set_blk(2, 28'h2000000, 2'd0, 1'b0, 1'b0);
    set_blk(3, 28'h3000000, 2'd0, 1'b0, 1'b0);
    cfg_page4k = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic xfer(input logic [27:0] a);
    @(negedge clk);
    in_valid = 1'b1; in_addr = a;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [7:0] e_ras, input logic [16:0] e_row,
                     input logic [9:0] e_col, input logic e_hit, input logic e_miss,
                     input logic e_conf);
    n_chk++;
    if (out_valid !== 1'b1 || out_ras !== e_ras || out_row !== e_row || out_col !== e_col ||
        out_hit !== e_hit || out_miss !== e_miss || out_conflict !== e_conf) begin
      n_fail++;
      $display("FAIL %s: got v=%b ras=%h row=%h col=%h hit=%b miss=%b conf=%b exp v=1 ras=%h row=%h col=%h hit=%b miss=%b conf=%b",
               tag, out_valid, out_ras, out_row, out_col, out_hit, out_miss, out_conflict,
               e_ras, e_row, e_col, e_hit, e_miss, e_conf);
    end
  endtask

  task automatic t_reset_state();
    cfg_plain();
    do_reset();
    n_chk++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1 || out_ras !== 8'h00 || out_hit !== 1'b0) begin
      n_fail++;
      $display("FAIL R8 reset: got v=%b rdy=%b ras=%h hit=%b exp v=0 rdy=1 ras=00 hit=0",
               out_valid, in_ready, out_ras, out_hit);
    end
  endtask

  task automatic t_plain();
    cfg_plain();
    do_reset();
    xfer(28'h0012348); chk("R1 R9 plain 2K", 8'h01, 17'h24, 10'h0D2, 0, 0, 0);
    cfg_page4k = 1'b1;
    xfer(28'h0012348); chk("R2 plain 4K", 8'h01, 17'h12, 10'h0D2, 0, 0, 0);
    cfg_page4k = 1'b0;
    xfer(28'h00FFFFC); chk("R1 top of bank", 8'h01, 17'h1FF, 10'h1FF, 0, 0, 0);
    xfer(28'h0100000); chk("R7 past bank", 8'h00, 17'h0, 10'h0, 0, 1, 0);
  endtask

  task automatic t_pair();
    cfg_plain();
    set_blk(1, 28'h0000000, 2'd0, 1'b0, 1'b1);
    set_blk(0, 28'h0000000, 2'd0, 1'b0, 1'b1);
    do_reset();
    xfer(28'h0000800); chk("R5 odd page to block1", 8'h02, 17'h0, 10'h0, 0, 0, 0);
    xfer(28'h0001000); chk("R3 even page to block0", 8'h01, 17'h1, 10'h0, 0, 0, 0);
    xfer(28'h01FF804); chk("R3 doubled range", 8'h02, 17'h1FF, 10'h1, 0, 0, 0);
    xfer(28'h0200000); chk("R7 past pair", 8'h00, 17'h0, 10'h0, 0, 1, 0);
    cfg_page4k = 1'b1;
    xfer(28'h0001000); chk("R2 4K bit12 odd", 8'h02, 17'h0, 10'h0, 0, 0, 0);
    xfer(28'h0000800); chk("R2 4K bit12 even", 8'h01, 17'h0, 10'h200, 0, 0, 0);
  endtask

  task automatic t_dual();
    cfg_plain();
    set_blk(2, 28'h2000000, 2'd0, 1'b1, 1'b0);
    do_reset();
    xfer(28'h2000800); chk("R4 second bank", 8'h40, 17'h0, 10'h0, 0, 0, 0);
    xfer(28'h2000004); chk("R4 first bank", 8'h04, 17'h0, 10'h1, 0, 0, 0);
    xfer(28'h21FFFFC); chk("R4 R9 top of pair", 8'h40, 17'h1FF, 10'h1FF, 0, 0, 0);
    set_blk(2, 28'h2000000, 2'd0, 1'b1, 1'b1);
    xfer(28'h2000800); chk("R4 ilv ignored", 8'h40, 17'h0, 10'h0, 0, 0, 0);
  endtask

  task automatic t_conflict();
    cfg_plain();
    set_blk(0, 28'h0000000, 2'd0, 1'b0, 1'b1);
    set_blk(2, 28'h0000000, 2'd0, 1'b0, 1'b1);
    do_reset();
    xfer(28'h0000100); chk("R6 two even blocks", 8'h01, 17'h0, 10'h40, 0, 0, 1);
    xfer(28'h0000800); chk("R6 R7 odd page empty", 8'h00, 17'h0, 10'h0, 0, 1, 0);
  endtask

  task automatic t_page();
    cfg_plain();
    do_reset();
    xfer(28'h0012348); chk("R8 first open", 8'h01, 17'h24, 10'h0D2, 0, 0, 0);
    xfer(28'h0012348); chk("R8 same row", 8'h01, 17'h24, 10'h0D2, 1, 0, 0);
    xfer(28'h1000000); chk("R8 other line", 8'h02, 17'h0, 10'h0, 0, 0, 0);
    xfer(28'h0012000); chk("R8 row kept", 8'h01, 17'h24, 10'h0, 1, 0, 0);
    xfer(28'h0013000); chk("R8 new row", 8'h01, 17'h26, 10'h0, 0, 0, 0);
    xfer(28'h0012348); chk("R8 old row closed", 8'h01, 17'h24, 10'h0D2, 0, 0, 0);
    xfer(28'h0100000); chk("R8 miss", 8'h00, 17'h0, 10'h0, 0, 1, 0);
    xfer(28'h0012348); chk("R8 miss no update", 8'h01, 17'h24, 10'h0D2, 1, 0, 0);
  endtask

  task automatic t_stall();
    cfg_plain();
    do_reset();
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_addr = 28'h0012348;
    @(negedge clk);
    chk("R10 latency", 8'h01, 17'h24, 10'h0D2, 0, 0, 0);
    in_addr = 28'h0013000;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R10 hold", 8'h01, 17'h24, 10'h0D2, 0, 0, 0);
      n_chk++;
      if (in_ready !== 1'b0) begin
        n_fail++;
        $display("FAIL R10 ready during stall: got %b exp 0", in_ready);
      end
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 waiting addr", 8'h01, 17'h26, 10'h0, 0, 0, 0);
    @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R10 drain: got out_valid=%b exp 0", out_valid);
    end
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1; in_addr = '0;
    cfg_start = '0; cfg_size = '0; cfg_dual = '0; cfg_ilv = '0; cfg_page4k = 1'b0;
    t_reset_state();
    t_plain();
    t_pair();
    t_dual();
    t_conflict();
    t_page();
    t_stall();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule